// File: doc/BRIEF.md
# Sleep-State Sequencer with Mains-Loss Recovery

This block follows the platform through three power conditions: fully working (S0), suspended with memory still powered (S3) and soft off (S5). Each clock it reads decoded requests to suspend or to switch off, a wake or power-button event, and a flag that says whether mains power is present. From these it moves between the three states. It allows only the legal moves and drives the enable for the main supply.

A move from suspend straight to off is never made. Such a request goes through the working state first. Waking from soft off passes through a single-cycle suspend-coded step before the working state is reached, and the off state can never come to rest in suspend. A single retained bit remembers whether the system was last on or off. When mains comes back, a two-bit recovery setting decides whether the system powers itself up. The setting can force power on, keep the system off, or follow the retained bit.

Top module: `acpi_sleep_ctl`

## Requirements
- R1: While rst_n is low and in the first cycle after release, pwr_state reads 2'b10 (off), and supply_en, req_blocked and last_on are all 0.
- R2: pwr_state codes are 2'b00 working, 2'b01 suspended, 2'b10 off. In the working state with mains present, req_off moves to off on the next edge, and so does req_off together with req_suspend. req_suspend alone moves to suspended. Either request wins over a simultaneous wake_evt.
- R3: In the suspended state with mains present, wake_evt without req_off moves to the working state on the next edge. With no input asserted, the state stays suspended.
- R4: In the suspended state, req_off never leads directly to off. The next state is working, with req_blocked high for that one cycle. One cycle later the state is off, whatever the inputs are.
- R5: In the off state, wake_evt moves through exactly one cycle of 2'b01 with supply_en high, then reaches the working state.
- R6: In the off state, req_suspend is blocked: req_blocked is high in the following cycle. Without wake_evt the state stays off.
- R7: With mains present, supply_en is 1 in the working state and in the wake step, and 0 while suspended or off.
- R8: While mains_ok is 0, supply_en is 0 in the same cycle, the state is off after the next edge, and all requests and wake events are ignored.
- R9: On the first edge where mains_ok is 1 again, restore_mode decides the next state. 2'b01 starts the wake step. 2'b00 and 2'b11 stay off. 2'b10 starts the wake step only if last_on is 1.
- R10: While mains is present, last_on becomes 1 when the next state is working and 0 when the next state is suspended or off. It holds during the wake step and while mains is absent.
- R11: Requests and wake events are ignored during the wake step, during the working cycle of the off detour, and in the mains-restore cycle, and they raise no req_blocked there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mains_ok | input | 1 | Mains power present |
| req_suspend | input | 1 | Request to suspend to memory |
| req_off | input | 1 | Request to soft off |
| wake_evt | input | 1 | Wake or power-button event |
| restore_mode | input | 2 | Policy when mains returns: 00 off, 01 on, 10 keep last, 11 off |
| pwr_state | output | 2 | Visible state: 00 working, 01 suspended, 10 off |
| supply_en | output | 1 | Main supply enable |
| req_blocked | output | 1 | One-cycle flag for a blocked illegal request |
| last_on | output | 1 | Retained last power condition |

## Verification
The bench builds the block with its default two-bit recovery field. This keeps every input combination small enough to enumerate. Starting from each of the three resting states, it applies all eight combinations of suspend request, off request and wake, then follows the detour and the wake step to the end. For the mains-loss path it covers all four recovery codes, each with the retained bit both set and clear, and it drives requests during the outage and during the restore cycle to show that they are ignored.

// File: rtl/acpi_pwr_pkg.sv
// Package acpi_pwr_pkg
// Shared state type, recovery-mode codes and the mapping from internal
// state to the two-bit visible code. Assumes the mode field stays two bits.
package acpi_pwr_pkg;

    localparam int MODE_W = 2;
    localparam int VIS_W  = 2;

    // Internal states: three resting states plus two single-cycle passes
    typedef enum logic [2:0] {
        PS_ON   = 3'd0,
        PS_SUSP = 3'd1,
        PS_OFF  = 3'd2,
        PS_WAKE = 3'd3,
        PS_EXIT = 3'd4
    } pstate_t;

    localparam logic [MODE_W-1:0] MODE_OFF  = 2'b00;
    localparam logic [MODE_W-1:0] MODE_ON   = 2'b01;
    localparam logic [MODE_W-1:0] MODE_KEEP = 2'b10;

    localparam logic [VIS_W-1:0] VIS_ON   = 2'b00;
    localparam logic [VIS_W-1:0] VIS_SUSP = 2'b01;
    localparam logic [VIS_W-1:0] VIS_OFF  = 2'b10;

    // Map internal state to the code seen at the port
    function automatic logic [VIS_W-1:0] vis_code(input pstate_t s);
        case (s)
            PS_ON, PS_EXIT:   vis_code = VIS_ON;
            PS_SUSP, PS_WAKE: vis_code = VIS_SUSP;
            default:          vis_code = VIS_OFF;
        endcase
    endfunction

    // States in which the main supply is driven
    function automatic logic is_powered(input pstate_t s);
        is_powered = (s == PS_ON) || (s == PS_EXIT) || (s == PS_WAKE);
    endfunction

endpackage

// File: rtl/acpi_mains_track.sv
// Module acpi_mains_track
// Remembers the previous mains flag and marks the first cycle in which
// mains is present again. Assumes mains_ok is already synchronous to clk.
// Reset clears the history, so mains present at reset release counts as a
// return of mains.
module acpi_mains_track (
    input  logic clk,
    input  logic rst_n,
    input  logic mains_ok,
    output logic restore_cyc
);

    logic mains_q;

    // Keep one cycle of mains history
    always_ff @(posedge clk) begin
        if (!rst_n) mains_q <= 1'b0;
        else        mains_q <= mains_ok;
    end

    // Rising-edge mark of mains presence
    always_comb restore_cyc = mains_ok && !mains_q;

endmodule

// File: rtl/acpi_restore_policy.sv
// Module acpi_restore_policy
// Decides, from the recovery setting and the retained bit, whether the
// system should power up when mains returns. Purely combinational; any
// unlisted code is treated as stay-off.
module acpi_restore_policy
    import acpi_pwr_pkg::*;
(
    input  logic [MODE_W-1:0] restore_mode,
    input  logic              last_on,
    output logic              power_up
);

    // Select the power-up decision by mode
    always_comb begin
        case (restore_mode)
            MODE_ON:   power_up = 1'b1;
            MODE_KEEP: power_up = last_on;
            MODE_OFF:  power_up = 1'b0;
            default:   power_up = 1'b0;
        endcase
    end

endmodule

// File: rtl/acpi_state_seq.sv
// Module acpi_state_seq
// Holds the power state and computes the next state. It reroutes
// suspend-to-off through the working state, sends wakes from off through
// one suspend-coded step, forces off while mains is absent, and registers
// a one-cycle flag for each blocked request. Assumes the inputs are
// synchronous and already decoded to one bit each.
module acpi_state_seq
    import acpi_pwr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    mains_ok,
    input  logic    restore_cyc,
    input  logic    power_up,
    input  logic    req_suspend,
    input  logic    req_off,
    input  logic    wake_evt,
    output pstate_t st,
    output pstate_t st_nxt,
    output logic    blocked
);

    logic blk_d;

    // Next-state selection, with mains loss and restore taking precedence
    always_comb begin
        st_nxt = st;
        blk_d  = 1'b0;
        if (!mains_ok) begin
            st_nxt = PS_OFF;
        end else if (restore_cyc) begin
            st_nxt = power_up ? PS_WAKE : PS_OFF;
        end else begin
            case (st)
                PS_ON: begin
                    if (req_off)          st_nxt = PS_OFF;
                    else if (req_suspend) st_nxt = PS_SUSP;
                end
                PS_SUSP: begin
                    if (req_off) begin
                        st_nxt = PS_EXIT;
                        blk_d  = 1'b1;
                    end else if (wake_evt) begin
                        st_nxt = PS_ON;
                    end
                end
                PS_OFF: begin
                    blk_d = req_suspend;
                    if (wake_evt) st_nxt = PS_WAKE;
                end
                PS_WAKE: st_nxt = PS_ON;
                PS_EXIT: st_nxt = PS_OFF;
                default: st_nxt = PS_OFF;
            endcase
        end
    end

    // State and blocked-flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= PS_OFF;
            blocked <= 1'b0;
        end else begin
            st      <= st_nxt;
            blocked <= blk_d;
        end
    end

endmodule

// File: rtl/acpi_last_state.sv
// Module acpi_last_state
// Retained record of the last power condition. It updates only while
// mains is present: set when heading to working, cleared when heading to
// suspend or off, held through the wake step. Reset value is a parameter.
module acpi_last_state
    import acpi_pwr_pkg::*;
#(
    parameter logic RST_VAL = 1'b0
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    mains_ok,
    input  pstate_t st_nxt,
    output logic    last_on
);

    // Record the destination of each move while mains is present
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_on <= RST_VAL;
        end else if (mains_ok) begin
            case (st_nxt)
                PS_ON, PS_EXIT:  last_on <= 1'b1;
                PS_SUSP, PS_OFF: last_on <= 1'b0;
                default:         last_on <= last_on;
            endcase
        end
    end

endmodule

// File: rtl/acpi_sleep_ctl.sv
// Module acpi_sleep_ctl (top)
// Sleep-state sequencer with mains-loss recovery. Combines mains tracking,
// the restore policy, the state sequencer and the retained last-state bit,
// and gates the supply enable directly with mains presence. Assumes all
// inputs are synchronous to clk.
module acpi_sleep_ctl
    import acpi_pwr_pkg::*;
#(
    parameter logic LAST_RST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mains_ok,
    input  logic              req_suspend,
    input  logic              req_off,
    input  logic              wake_evt,
    input  logic [MODE_W-1:0] restore_mode,
    output logic [VIS_W-1:0]  pwr_state,
    output logic              supply_en,
    output logic              req_blocked,
    output logic              last_on
);

    logic    restore_cyc;
    logic    power_up;
    pstate_t st;
    pstate_t st_nxt;

    acpi_mains_track u_mains (
        .clk         (clk),
        .rst_n       (rst_n),
        .mains_ok    (mains_ok),
        .restore_cyc (restore_cyc)
    );

    acpi_restore_policy u_policy (
        .restore_mode (restore_mode),
        .last_on      (last_on),
        .power_up     (power_up)
    );

    acpi_state_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mains_ok    (mains_ok),
        .restore_cyc (restore_cyc),
        .power_up    (power_up),
        .req_suspend (req_suspend),
        .req_off     (req_off),
        .wake_evt    (wake_evt),
        .st          (st),
        .st_nxt      (st_nxt),
        .blocked     (req_blocked)
    );

    acpi_last_state #(.RST_VAL(LAST_RST)) u_last (
        .clk      (clk),
        .rst_n    (rst_n),
        .mains_ok (mains_ok),
        .st_nxt   (st_nxt),
        .last_on  (last_on)
    );

    // Visible state code and mains-gated supply enable
    always_comb begin
        pwr_state = vis_code(st);
        supply_en = mains_ok && is_powered(st);
    end

endmodule

// File: rtl/acpi_sleep_ctl_chk.sv
// Module acpi_sleep_ctl_chk
// Port-level temporal checks for acpi_sleep_ctl, bound to every instance.
module acpi_sleep_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mains_ok,
    input logic [1:0] pwr_state,
    input logic       supply_en,
    input logic       req_blocked,
    input logic       last_on
);

    // Suspended never goes straight to off while mains is present
    p_no_direct_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mains_ok && pwr_state == 2'b01) |=> pwr_state != 2'b10);

    // The suspend-coded step entered from off always ends in working
    p_wake_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mains_ok && pwr_state == 2'b01 && $past(pwr_state) == 2'b10) |=> pwr_state == 2'b00);

    // Blocked flag only follows a suspended or off state
    p_blocked_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_blocked |-> ($past(pwr_state) == 2'b10 || $past(pwr_state) == 2'b01));

    // Supply is never driven in the off state
    p_off_unpowered_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state == 2'b10 |-> !supply_en);

    // Mains absence drops supply at once
    p_supply_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mains_ok |-> !supply_en);

    // Mains absence forces off on the next edge
    p_forced_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mains_ok |=> pwr_state == 2'b10);

    // Retained bit is frozen while mains is absent
    p_last_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mains_ok |=> $stable(last_on));

endmodule

bind acpi_sleep_ctl acpi_sleep_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mains_ok    (mains_ok),
    .pwr_state   (pwr_state),
    .supply_en   (supply_en),
    .req_blocked (req_blocked),
    .last_on     (last_on)
);

// File: tb/acpi_sleep_ctl_tb.sv
module acpi_sleep_ctl_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mains_ok;
    logic       req_suspend;
    logic       req_off;
    logic       wake_evt;
    logic [1:0] restore_mode;
    logic [1:0] pwr_state;
    logic       supply_en;
    logic       req_blocked;
    logic       last_on;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    acpi_sleep_ctl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mains_ok     (mains_ok),
        .req_suspend  (req_suspend),
        .req_off      (req_off),
        .wake_evt     (wake_evt),
        .restore_mode (restore_mode),
        .pwr_state    (pwr_state),
        .supply_en    (supply_en),
        .req_blocked  (req_blocked),
        .last_on      (last_on)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_in();
        req_suspend = 1'b0;
        req_off     = 1'b0;
        wake_evt    = 1'b0;
    endtask

    // Reset with mains present and policy on: restore step, then working
    task automatic boot_on();
        rst_n = 1'b0;
        mains_ok = 1'b1;
        restore_mode = 2'b01;
        clear_in();
        step();
        step();
        rst_n = 1'b1;
        step();
        step();
    endtask

    // Reach a resting state: 0 working, 1 suspended, 2 off
    task automatic goto(input int s);
        boot_on();
        if (s == 1) begin req_suspend = 1'b1; step(); clear_in(); end
        if (s == 2) begin req_off = 1'b1; step(); clear_in(); end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        mains_ok = 1'b1;
        restore_mode = 2'b00;
        clear_in();
        step();
        // R1: reset state
        check("R1 state", pwr_state, 2'b10);
        check("R1 supply", supply_en, 0);
        check("R1 blocked", req_blocked, 0);
        check("R1 last", last_on, 0);
        rst_n = 1'b1;
        step();
        check("R1 first cycle state", pwr_state, 2'b10);
        check("R1 first cycle supply", supply_en, 0);

        // Sweep: every resting state against every request combination
        for (int s = 0; s < 3; s++) begin
            for (int c = 0; c < 8; c++) begin
                logic r3, r5, w;
                logic [1:0] e_st, e_st2;
                logic e_blk, e_sup, e_last, two;
                string tg;
                r3 = c[0]; r5 = c[1]; w = c[2];
                two = 1'b0; e_st2 = 2'b00;
                goto(s);
                req_suspend = r3; req_off = r5; wake_evt = w;
                step();
                clear_in();
                if (s == 0) begin
                    tg = "R2";
                    if (r5)      begin e_st = 2'b10; e_blk = 0; e_sup = 0; e_last = 0; end
                    else if (r3) begin e_st = 2'b01; e_blk = 0; e_sup = 0; e_last = 0; end
                    else         begin e_st = 2'b00; e_blk = 0; e_sup = 1; e_last = 1; end
                end else if (s == 1) begin
                    if (r5) begin
                        tg = "R4"; e_st = 2'b00; e_blk = 1; e_sup = 1; e_last = 1;
                        two = 1'b1; e_st2 = 2'b10;
                    end else if (w) begin
                        tg = "R3"; e_st = 2'b00; e_blk = 0; e_sup = 1; e_last = 1;
                    end else begin
                        tg = "R3"; e_st = 2'b01; e_blk = 0; e_sup = 0; e_last = 0;
                    end
                end else begin
                    if (w) begin
                        tg = "R5"; e_st = 2'b01; e_blk = r3; e_sup = 1; e_last = 0;
                        two = 1'b1; e_st2 = 2'b00;
                    end else begin
                        tg = "R6"; e_st = 2'b10; e_blk = r3; e_sup = 0; e_last = 0;
                    end
                end
                check($sformatf("%s state s=%0d c=%0d", tg, s, c), pwr_state, e_st);
                check($sformatf("R6 blocked s=%0d c=%0d", s, c), req_blocked, e_blk);
                check($sformatf("R7 supply s=%0d c=%0d", s, c), supply_en, e_sup);
                check($sformatf("R10 last s=%0d c=%0d", s, c), last_on, e_last);
                if (two) begin
                    // R11: inputs during the pass cycle are ignored
                    req_suspend = 1'b1; wake_evt = 1'b1;
                    step();
                    clear_in();
                    check($sformatf("%s second state s=%0d c=%0d", tg, s, c), pwr_state, e_st2);
                    check($sformatf("R11 blocked s=%0d c=%0d", s, c), req_blocked, 0);
                    check($sformatf("R7 second supply s=%0d c=%0d", s, c), supply_en, (e_st2 == 2'b00) ? 1 : 0);
                    check($sformatf("R10 second last s=%0d c=%0d", s, c), last_on, (e_st2 == 2'b00) ? 1 : 0);
                end
            end
        end

        // R11: off request during the wake step is ignored
        goto(2);
        wake_evt = 1'b1; req_off = 1'b1;
        step();
        wake_evt = 1'b0;
        check("R5 wake step", pwr_state, 2'b01);
        step();
        check("R11 off ignored in wake step", pwr_state, 2'b00);
        step();
        clear_in();
        check("R2 off after wake", pwr_state, 2'b10);

        // Mains loss and restore across every mode and retained value
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 2; k++) begin
                logic pon;
                pon = (m == 1) || (m == 2 && k == 1);
                goto((k == 1) ? 0 : 2);
                check($sformatf("R10 memo m=%0d k=%0d", m, k), last_on, k);
                mains_ok = 1'b0;
                #1;
                check($sformatf("R8 supply drop m=%0d k=%0d", m, k), supply_en, 0);
                step();
                check($sformatf("R8 forced off m=%0d k=%0d", m, k), pwr_state, 2'b10);
                check($sformatf("R10 hold m=%0d k=%0d", m, k), last_on, k);
                wake_evt = 1'b1; req_suspend = 1'b1;
                step();
                clear_in();
                check($sformatf("R8 ignored m=%0d k=%0d", m, k), pwr_state, 2'b10);
                check($sformatf("R8 no blocked m=%0d k=%0d", m, k), req_blocked, 0);
                check($sformatf("R8 last m=%0d k=%0d", m, k), last_on, k);
                mains_ok = 1'b1;
                restore_mode = m[1:0];
                wake_evt = 1'b1; req_suspend = 1'b1;
                step();
                clear_in();
                check($sformatf("R9 restore state m=%0d k=%0d", m, k), pwr_state, pon ? 2'b01 : 2'b10);
                check($sformatf("R11 restore blocked m=%0d k=%0d", m, k), req_blocked, 0);
                check($sformatf("R7 restore supply m=%0d k=%0d", m, k), supply_en, pon);
                step();
                check($sformatf("R9 settled m=%0d k=%0d", m, k), pwr_state, pon ? 2'b00 : 2'b10);
                check($sformatf("R10 after restore m=%0d k=%0d", m, k), last_on, pon);
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule